// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block arbitrates among a configurable number of level-sensitive interrupt sources, 16 by default, on behalf of a processor core. Each source has an 8-bit priority register. Only the upper `PRIO_BITS` bits of that register hold state. A smaller stored value means a more urgent source. A 3-bit grouping field divides every priority into two parts. The upper part is a preemption level that decides nesting. The lower part is a subpriority that only orders requests which are waiting together. A base-priority mask lets software block every source at or below a chosen urgency.

Requests are latched into pending bits. Each cycle the controller picks the best pending request that the mask lets through. It offers that request on `irq_valid`/`irq_id` when no handler is running, or when the request's preemption level beats the running level. The core accepts an offer with `irq_take`. The source then moves from pending onto a nesting stack. A pulse on `eoh` ends the most recently taken handler, and the running level falls back to what was running before it.

Top module: `pic_ctrl`

## Requirements
- R1: Register map: addresses 0 to NUM_SRC-1 are the source priorities, address NUM_SRC is the grouping field in bits [2:0], and address NUM_SRC+1 is the mask. Priority and mask registers store only their top PRIO_BITS bits, and the low bits read as zero: with PRIO_BITS=3, writing 0xFF reads back 0xE0. `reg_rdata` shows, one cycle later, the register at `reg_addr` as it was before any write in that cycle. Unmapped addresses read 0.
- R2: A high `irq_req` bit sets that source's pending bit, and the bit stays set after the request drops. Taking the source clears the bit. The source's request in the take cycle is ignored.
- R3: Among eligible pending sources, the one with the numerically smallest priority value wins. Equal values go to the lowest source index.
- R4: While the mask is nonzero, a source whose priority is greater than or equal to the mask is not eligible. A mask of 0 blocks nothing.
- R5: The preemption level of a priority is that value with bits [G:0] cleared, where G is the grouping field. The winner is offered when no handler is active, or when its level is strictly below the running level. The running level is the lowest level among the active sources.
- R6: With G=7 no offer is made while any handler is active. With G at or below 7-PRIO_BITS, all implemented bits count as preemption level.
- R7: `irq_valid`/`irq_id` are registered and reflect the state of the previous cycle. An offer stays up until `irq_take`. After a take, `irq_valid` is low in the next cycle.
- R8: `eoh` removes the most recently taken source from the active stack and restores the previous running level. `eoh` with no active source is ignored.
- R9: Reset clears the priorities, the grouping field, the mask, the pending bits and the stack, and drives `irq_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_SRC | Level interrupt requests |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| irq_valid | output | 1 | An interrupt is offered to the core |
| irq_id | output | ID_W | Offered source index |
| irq_take | input | 1 | Core accepts the offered source |
| eoh | input | 1 | End of the current handler |

## Verification
The bench looks for the places where a nesting controller tends to go wrong:
- Equal preemption levels must not nest, even when the subpriorities differ. A design that compared full priorities would preempt in that case.
- G=7 must freeze nesting entirely.
- A mask equal to a source's priority must block that source. An off-by-one comparison would let the source through.
- Ties between equal values must go to the lowest index.
- A request held high through its own take cycle must not leave the source pending again.
- Every end-of-handler pulse must reinstate the earlier running level. A stack that lost that level would release the waiting requests too early, or hold them back too long.

A reference model mirrors the requirements through thousands of random cycles. It covers register writes, grouping changes, nested takes and ends of handler, and it compares the offer and the read data on every cycle.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PRIO_W = 8;
  localparam int GRP_W  = 3;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [GRP_W-1:0]  grp_t;

  // Clear the subpriority bits [g:0], leaving the preemption level.
  function automatic prio_t preempt_key(prio_t p, grp_t g);
    logic [PRIO_W:0] low;
    low = (9'd2 << g) - 9'd1;
    return p & ~low[PRIO_W-1:0];
  endfunction
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import pic_pkg::*;
#(
  parameter int NUM_SRC   = 16,
  parameter int PRIO_BITS = 3,
  parameter int ADDR_W    = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  prio_t                     wdata,
  output prio_t                     rdata,
  output logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output grp_t                      group,
  output prio_t                     mask
);
  localparam prio_t IMPL = prio_t'(8'hFF << (PRIO_W - PRIO_BITS));
  localparam logic [ADDR_W-1:0] GRP_ADDR  = ADDR_W'(NUM_SRC);
  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(NUM_SRC + 1);

  // one register per source, only implemented bits kept
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
    prio_t prio_q;
    always_ff @(posedge clk) begin
      if (rst) prio_q <= '0;
      else if (wr_en && addr == ADDR_W'(i)) prio_q <= wdata & IMPL;
    end
    assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      group <= '0;
      mask  <= '0;
    end else if (wr_en) begin
      if (addr == GRP_ADDR)  group <= wdata[GRP_W-1:0];
      if (addr == MASK_ADDR) mask  <= wdata & IMPL;
    end
  end

  prio_t rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (addr == ADDR_W'(i)) rd_mux = prio_flat[i*PRIO_W +: PRIO_W];
    if (addr == GRP_ADDR)  rd_mux = prio_t'(group);
    if (addr == MASK_ADDR) rd_mux = mask;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/pic_select.sv
module pic_select
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int ID_W    = 4
) (
  input  logic [NUM_SRC-1:0]        pending,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  input  prio_t                     mask,
  output logic                      found,
  output logic [ID_W-1:0]           best_id,
  output prio_t                     best_prio
);
  logic [NUM_SRC-1:0] eligible;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    assign eligible[i] = pending[i] &&
      !(mask != '0 && prio_flat[i*PRIO_W +: PRIO_W] >= mask);
  end

  // scan from the top index down so that ties settle on the lowest index
  always_comb begin
    prio_t p;
    found     = 1'b0;
    best_id   = '0;
    best_prio = '1;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      p = prio_flat[i*PRIO_W +: PRIO_W];
      if (eligible[i] && (!found || p <= best_prio)) begin
        found     = 1'b1;
        best_id   = ID_W'(i);
        best_prio = p;
      end
    end
  end
endmodule

// File: rtl/pic_nest_stack.sv
module pic_nest_stack
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int ID_W    = 4,
  parameter int SP_W    = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      push,
  input  logic [ID_W-1:0]           push_id,
  input  logic                      pop,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  input  grp_t                      group,
  output logic [SP_W-1:0]           sp,
  output logic                      run_valid,
  output prio_t                     run_key
);
  logic [ID_W-1:0] stk [NUM_SRC];
  logic            do_pop, do_push;
  logic [SP_W-1:0] base;

  assign do_pop  = pop && sp != '0;
  assign base    = sp - SP_W'(do_pop);
  assign do_push = push && base < SP_W'(NUM_SRC);

  always_ff @(posedge clk) begin
    if (do_push) stk[base[ID_W-1:0]] <= push_id;
  end

  always_ff @(posedge clk) begin
    if (rst) sp <= '0;
    else     sp <= base + SP_W'(do_push);
  end

  // running level: most urgent preemption level among active entries
  always_comb begin
    prio_t k;
    run_valid = sp != '0;
    run_key   = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      k = preempt_key(prio_flat[stk[i]*PRIO_W +: PRIO_W], group);
      if (SP_W'(i) < sp && k < run_key) run_key = k;
    end
  end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_SRC   = 16,
  parameter int PRIO_BITS = 3,
  localparam int ADDR_W   = $clog2(NUM_SRC + 2),
  localparam int ID_W     = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic               irq_valid,
  output logic [ID_W-1:0]    irq_id,
  input  logic               irq_take,
  input  logic               eoh
);
  localparam int SP_W = $clog2(NUM_SRC + 1);

  if (PRIO_BITS < 3 || PRIO_BITS > PRIO_W) begin : g_bad_cfg
    $error("PRIO_BITS must lie in 3..8");
  end

  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  grp_t                      group_q;
  prio_t                     mask_q;
  logic [NUM_SRC-1:0]        pending;
  logic                      found;
  logic [ID_W-1:0]           best_id;
  prio_t                     best_prio;
  logic [SP_W-1:0]           sp;
  logic                      run_valid;
  prio_t                     run_key;
  logic                      take_hit;
  logic                      offer;
  logic [NUM_SRC-1:0]        take_vec;

  pic_cfg_regs #(.NUM_SRC(NUM_SRC), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .prio_flat(prio_flat), .group(group_q), .mask(mask_q)
  );

  pic_select #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_sel (
    .pending(pending), .prio_flat(prio_flat), .mask(mask_q),
    .found(found), .best_id(best_id), .best_prio(best_prio)
  );

  pic_nest_stack #(.NUM_SRC(NUM_SRC), .ID_W(ID_W), .SP_W(SP_W)) u_stk (
    .clk(clk), .rst(rst), .push(take_hit), .push_id(irq_id), .pop(eoh),
    .prio_flat(prio_flat), .group(group_q), .sp(sp),
    .run_valid(run_valid), .run_key(run_key)
  );

  assign take_hit = irq_take && irq_valid;
  assign take_vec = take_hit ? (NUM_SRC'(1) << irq_id) : '0;
  assign offer    = found &&
                    (!run_valid || preempt_key(best_prio, group_q) < run_key);

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= '0;
      irq_valid <= 1'b0;
      irq_id    <= '0;
    end else begin
      pending   <= (pending | irq_req) & ~take_vec;
      irq_valid <= offer && !take_hit;
      if (offer) irq_id <= best_id;
    end
  end
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk #(
  parameter int NUM_SRC   = 16,
  parameter int PRIO_BITS = 3,
  parameter int ADDR_W    = 5,
  parameter int ID_W      = 4,
  parameter int SP_W      = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 irq_valid,
  input logic [ID_W-1:0]      irq_id,
  input logic                 irq_take,
  input logic                 eoh,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [7:0]           reg_rdata,
  input logic [SP_W-1:0]      depth,
  input logic [2:0]           grp,
  input logic [7:0]           mask,
  input logic [NUM_SRC*8-1:0] prio_flat
);
  localparam logic [7:0] LOW = 8'(~(8'hFF << (8 - PRIO_BITS)));

  logic [NUM_SRC*8-1:0] prio_d;
  logic [7:0]           mask_d;
  logic [ADDR_W-1:0]    addr_d;
  always_ff @(posedge clk) begin
    prio_d <= prio_flat;
    mask_d <= mask;
    addr_d <= reg_addr;
  end

  // R9
  reset_idle_chk: assert property (@(posedge clk) rst |=> !irq_valid);

  // R1
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_d < ADDR_W'(NUM_SRC)) |-> ((reg_rdata & LOW) == 8'h00));

  // R7
  take_drops_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_take && irq_valid) |=> !irq_valid);

  // R6
  no_nest_chk: assert property (@(posedge clk) disable iff (rst)
    (depth != '0 && grp == 3'd7) |=> !irq_valid);

  // R4
  mask_block_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && mask_d != 8'h00) |-> (prio_d[irq_id*8 +: 8] < mask_d));

  // R8
  pop_depth_chk: assert property (@(posedge clk) disable iff (rst)
    (eoh && depth != '0 && !(irq_take && irq_valid)) |=> (depth == $past(depth) - 1'b1));
endmodule

bind pic_ctrl pic_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W),
  .ID_W(ID_W), .SP_W(SP_W)
) u_chk (
  .clk(clk), .rst(rst), .irq_valid(irq_valid), .irq_id(irq_id),
  .irq_take(irq_take), .eoh(eoh), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .depth(sp), .grp(group_q), .mask(mask_q), .prio_flat(prio_flat)
);

// File: tb/tb_pic_ctrl.sv
module tb_pic_ctrl;
  localparam int NS = 16;
  localparam int PB = 3;
  localparam int AW = $clog2(NS + 2);
  localparam int IW = $clog2(NS);
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] IMPL = 8'(8'hFF << (8 - PB));

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] irq_req = '0;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          irq_valid;
  logic [IW-1:0] irq_id;
  logic          irq_take = 1'b0;
  logic          eoh = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pic_ctrl #(.NUM_SRC(NS), .PRIO_BITS(PB)) dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_valid(irq_valid),
    .irq_id(irq_id), .irq_take(irq_take), .eoh(eoh)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [7:0]    m_prio [NS];
  logic [2:0]    m_grp;
  logic [7:0]    m_mask;
  logic [NS-1:0] m_pend;
  int            m_stk [NS];
  int            m_sp;
  bit            e_valid;
  int            e_id;

  function automatic int lvl(logic [7:0] p);
    int low;
    low = (2 << m_grp) - 1;
    return int'(p) & ~low & 255;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NS; i++) m_prio[i] = 8'h00;
    m_grp = 3'd0; m_mask = 8'h00; m_pend = '0; m_sp = 0;
    e_valid = 1'b0; e_id = 0;
  endtask

  // one clock: drive at the falling edge, compare after the rising edge
  task automatic step(input logic [NS-1:0] req, input bit take, input bit end_h,
                      input bit wr, input int addr, input int wd);
    int best, run, e_rd;
    bit ok, take_eff;
    best = -1;
    for (int i = 0; i < NS; i++)
      if (m_pend[i] && !(m_mask != 0 && m_prio[i] >= m_mask) &&
          (best < 0 || m_prio[i] < m_prio[best])) best = i;
    run = 256;
    for (int k = 0; k < m_sp; k++)
      if (lvl(m_prio[m_stk[k]]) < run) run = lvl(m_prio[m_stk[k]]);
    ok = (best >= 0) && (m_sp == 0 || lvl(m_prio[best]) < run);
    if (addr < NS)           e_rd = m_prio[addr];
    else if (addr == NS)     e_rd = m_grp;
    else if (addr == NS + 1) e_rd = m_mask;
    else                     e_rd = 0;
    take_eff = take && e_valid;

    irq_req = req; irq_take = take; eoh = end_h;
    reg_wr = wr; reg_addr = AW'(addr); reg_wdata = 8'(wd);
    @(posedge clk);

    m_pend = m_pend | req;
    if (take_eff) m_pend[e_id] = 1'b0;
    if (end_h && m_sp > 0) m_sp--;
    if (take_eff && m_sp < NS) begin m_stk[m_sp] = e_id; m_sp++; end
    if (wr) begin
      if (addr < NS)           m_prio[addr] = 8'(wd) & IMPL;
      else if (addr == NS)     m_grp = 3'(wd);
      else if (addr == NS + 1) m_mask = 8'(wd) & IMPL;
    end
    e_valid = ok && !take_eff;
    if (ok) e_id = best;

    #1;
    check("R5 model offer", int'(irq_valid), int'(e_valid));
    if (e_valid) check("R3 model id", int'(irq_id), e_id);
    check("R1 model readback", int'(reg_rdata), e_rd);
    @(negedge clk);
    irq_take = 1'b0; eoh = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic idle(int n = 1);
    for (int i = 0; i < n; i++) step('0, 0, 0, 0, 0, 0);
  endtask
  task automatic wreg(int a, int d); step('0, 0, 0, 1, a, d); endtask
  task automatic rd(int a);          step('0, 0, 0, 0, a, 0); endtask
  task automatic req(int src);       step(NS'(1) << src, 0, 0, 0, 0, 0); endtask
  task automatic tk();               step('0, 1, 0, 0, 0, 0); endtask
  task automatic eh();               step('0, 0, 1, 0, 0, 0); endtask

  task automatic expect_offer(string tag, bit v, int id);
    check(tag, int'(irq_valid), int'(v));
    if (v) check(tag, int'(irq_id), id);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    check("R9 valid after reset", int'(irq_valid), 0);
    check("R9 rdata after reset", int'(reg_rdata), 0);
    rd(0);
    check("R9 priority reset value", int'(reg_rdata), 0);

    // R1: full data sweep on one priority register
    for (int d = 0; d < 256; d++) begin
      wreg(5, d);
      rd(5);
      check("R1 sweep", int'(reg_rdata), d & int'(IMPL));
    end
    check("R1 0xFF reads 0xE0", int'(reg_rdata), 8'hE0);
    wreg(5, 0);
    wreg(NS, 8'hFD); rd(NS);
    check("R1 group readback", int'(reg_rdata), 5);
    wreg(NS, 0);
    wreg(NS + 1, 8'h3F); rd(NS + 1);
    check("R1 mask readback", int'(reg_rdata), 8'h20);
    wreg(NS + 1, 0);
    rd(NS + 3);
    check("R1 unmapped reads zero", int'(reg_rdata), 0);

    // R3/R5/R7/R8: ordering and nesting with G=0
    wreg(3, 8'h40); wreg(7, 8'h20); wreg(9, 8'h20);
    step((NS'(1) << 3) | (NS'(1) << 7) | (NS'(1) << 9), 0, 0, 0, 0, 0);
    check("R7 offer one cycle after pending", int'(irq_valid), 0);
    idle();
    expect_offer("R3 smallest value, lowest index", 1, 7);
    idle();
    expect_offer("R7 offer held until take", 1, 7);
    tk();
    check("R7 take drops valid", int'(irq_valid), 0);
    idle();
    expect_offer("R5 equal level does not preempt", 0, 0);
    wreg(1, 8'h00); req(1); idle();
    expect_offer("R5 higher level preempts", 1, 1);
    tk(); idle();
    eh(); idle();
    expect_offer("R8 previous level restored", 0, 0);
    eh(); idle();
    expect_offer("R8 stack empty offers waiting", 1, 9);
    tk(); eh(); idle();
    expect_offer("R2 pending retained", 1, 3);
    tk(); eh(); idle();
    expect_offer("R2 pending cleared by take", 0, 0);
    eh(); req(3); idle();
    expect_offer("R8 eoh on empty ignored", 1, 3);
    tk(); eh(); idle();

    // R4: mask
    wreg(NS + 1, 8'h40); req(3); idle(2);
    expect_offer("R4 priority equal to mask blocked", 0, 0);
    req(9); idle();
    expect_offer("R4 below mask passes", 1, 9);
    tk(); eh();
    wreg(NS + 1, 0); idle();
    expect_offer("R4 zero mask unblocks", 1, 3);
    tk(); eh(); idle();

    // R6: grouping
    wreg(NS, 5); req(7); idle(); tk();
    req(1); idle();
    expect_offer("R6 same group level no preempt", 0, 0);
    eh(); idle();
    expect_offer("R6 after end offered", 1, 1);
    tk(); eh(); idle();
    wreg(NS, 7); req(3); idle(); tk();
    req(1); idle(2);
    expect_offer("R6 G=7 disables nesting", 0, 0);
    eh(); idle();
    expect_offer("R6 G=7 offered when idle", 1, 1);
    tk(); eh();
    wreg(NS, 2); req(7); idle(); tk();
    req(1); idle();
    expect_offer("R6 G in unimplemented bits preempts", 1, 1);
    tk(); eh(); eh(); idle();
    wreg(NS, 0);

    // R2: request held through its take cycle
    step(NS'(1) << 3, 0, 0, 0, 0, 0);
    step(NS'(1) << 3, 0, 0, 0, 0, 0);
    step(NS'(1) << 3, 1, 0, 0, 0, 0);
    idle();
    expect_offer("R2 take cycle request ignored", 0, 0);
    eh(); idle();
    expect_offer("R2 nothing left pending", 0, 0);

    // random phase against the model
    for (int n = 0; n < 4000; n++) begin
      logic [NS-1:0] r;
      bit t, e, w;
      int a;
      r = '0;
      for (int i = 0; i < NS; i++) r[i] = ($urandom % 12) == 0;
      t = e_valid && ($urandom % 2 == 0);
      e = (m_sp > 0) ? ($urandom % 5 == 0) : ($urandom % 40 == 0);
      w = ($urandom % 10) == 0;
      a = (w && $urandom % 4 == 0) ? NS + int'($urandom % 2) : int'($urandom % (NS + 4));
      step(r, t, e, w, a, int'($urandom % 256));
    end

    summary();
    $finish;
  end
endmodule